// File: doc/BRIEF.md
# Packed BCD byte add/subtract unit

This unit adds or subtracts two packed two-digit decimal bytes together with an incoming extend bit. The extend bit acts as carry-in for addition and as borrow-in for subtraction. It also computes the carry, extend, overflow, negative and zero flags. The arithmetic is a fixed sequence of eight-bit steps with wraparound: the low digits are combined, the low digit is corrected, the high digits are merged, and a final correction is applied. Operands that are not valid decimal digits therefore give a result that is exactly defined.

A request is accepted in any cycle where `in_valid` and `in_ready` are both high. Its result and flags appear in registers on the next cycle, with `out_valid` high. Longer decimal numbers are processed one byte at a time, least significant byte first. The caller feeds the extend and zero outputs of one byte back in as `in_x` and `in_z` for the next byte. Because the zero flag only ever clears, the final zero flag is set only when every byte of the chain came out zero.

Top module: `bcd_byte_alu`

## Requirements
- R1: `in_op` = 0 selects addition and `in_op` = 1 selects subtraction. The low digit intermediate is (dst & 0x0F) + (src & 0x0F) + X for addition, or (dst & 0x0F) − (src & 0x0F) − X for subtraction, computed as an 8-bit value with wraparound.
- R2: When that intermediate, read as an unsigned byte, is 0x0A or more, 6 is added to it (addition) or subtracted from it (subtraction). This includes wrapped values such as 0xFF and sums of non-decimal digits.
- R3: The corrected low value is added to (dst & 0xF0), with 8-bit wraparound. Then (src & 0xF0) is added or subtracted, and the carry or borrow out of this last step is kept.
- R4: If that last step produced a carry or borrow, or its byte is 0xA0 or more, C is set and 0x60 is added (addition) or subtracted (subtraction) to form the result. Otherwise C is clear and the byte is the result.
- R5: V is set only when the 0x60 correction of R4 overflows as a signed two's-complement byte. In every other case V is clear.
- R6: The X output always equals the C output.
- R7: The N output equals bit 7 of the result.
- R8: The Z output is 0 when the result is nonzero. When the result is zero, Z equals the `in_z` value of that request.
- R9: A request accepted at a clock edge sets `out_valid` and its result and flags in the next cycle. After a cycle with no accepted request, `out_valid` is low and the result and flags keep their previous values.
- R10: While the synchronous active-high `rst` is high, `in_ready` is low. A clock edge with `rst` high clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit accepts a request this cycle |
| in_op | input | 1 | 0 = add, 1 = subtract |
| in_dst | input | 8 | Destination (minuend / first addend) byte |
| in_src | input | 8 | Source byte |
| in_x | input | 1 | Incoming extend (carry/borrow in) |
| in_z | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Registered result present |
| out_res | output | 8 | Result byte |
| out_c | output | 1 | Carry/borrow out |
| out_x | output | 1 | Extend out |
| out_v | output | 1 | Overflow of the final correction |
| out_n | output | 1 | Result bit 7 |
| out_z | output | 1 | Chained zero flag |

## Verification
The bench builds the unit with the default digit width of four bits, which gives a byte-wide datapath. At that width, every one of the 65,536 destination and source byte pairs is driven under both operations, with the extend and zero inputs varied, and each result is compared to an independent integer model of the sequence. Directed cases cover decimal wraparound in both directions, non-decimal digits, both overflow directions, zero chaining, an idle cycle holding its values, and a reset arriving while a result is pending.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    typedef enum logic {
        BCD_ADD = 1'b0,
        BCD_SUB = 1'b1
    } bcd_op_e;

    typedef struct packed {
        logic c;
        logic x;
        logic v;
        logic n;
        logic z;
    } bcd_flags_t;

endpackage

// File: rtl/bcd_low_digit.sv
module bcd_low_digit
    import bcd_alu_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  bcd_op_e                  op,
    input  logic [DIGIT_W-1:0]       dst_lo,
    input  logic [DIGIT_W-1:0]       src_lo,
    input  logic                     x_in,
    output logic [2*DIGIT_W-1:0]     lo_fixed
);
    localparam int BYTE_W = 2 * DIGIT_W;
    localparam logic [BYTE_W-1:0] DEC_LIM = BYTE_W'(10);
    localparam logic [BYTE_W-1:0] DEC_COR = BYTE_W'(6);

    logic [BYTE_W-1:0] dst_w;
    logic [BYTE_W-1:0] src_w;
    logic [BYTE_W-1:0] cin_w;
    logic [BYTE_W-1:0] raw;

    always_comb begin
        dst_w = BYTE_W'(dst_lo);
        src_w = BYTE_W'(src_lo);
        cin_w = BYTE_W'(x_in);
        if (op == BCD_ADD) begin
            raw = dst_w + src_w + cin_w;
        end else begin
            raw = dst_w - src_w - cin_w;
        end
        // unsigned compare, so wrapped negatives also get corrected
        if (raw >= DEC_LIM) begin
            lo_fixed = (op == BCD_ADD) ? raw + DEC_COR : raw - DEC_COR;
        end else begin
            lo_fixed = raw;
        end
    end
endmodule

// File: rtl/bcd_high_merge.sv
module bcd_high_merge
    import bcd_alu_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  bcd_op_e                  op,
    input  logic [2*DIGIT_W-1:0]     lo_fixed,
    input  logic [DIGIT_W-1:0]       dst_hi,
    input  logic [DIGIT_W-1:0]       src_hi,
    output logic [2*DIGIT_W-1:0]     mid,
    output logic                     mid_cb
);
    localparam int BYTE_W = 2 * DIGIT_W;

    logic [BYTE_W-1:0] dh_w;
    logic [BYTE_W-1:0] sh_w;
    logic [BYTE_W-1:0] partial;
    logic [BYTE_W:0]   ext;

    always_comb begin
        dh_w    = {dst_hi, {DIGIT_W{1'b0}}};
        sh_w    = {src_hi, {DIGIT_W{1'b0}}};
        partial = lo_fixed + dh_w;
        if (op == BCD_ADD) begin
            ext = {1'b0, partial} + {1'b0, sh_w};
        end else begin
            ext = {1'b0, partial} - {1'b0, sh_w};
        end
        mid    = ext[BYTE_W-1:0];
        mid_cb = ext[BYTE_W];
    end
endmodule

// File: rtl/bcd_decimal_adjust.sv
module bcd_decimal_adjust
    import bcd_alu_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  bcd_op_e                  op,
    input  logic [2*DIGIT_W-1:0]     mid,
    input  logic                     mid_cb,
    output logic [2*DIGIT_W-1:0]     res,
    output logic                     c_out,
    output logic                     v_out
);
    localparam int BYTE_W = 2 * DIGIT_W;
    localparam int MSB    = BYTE_W - 1;
    localparam logic [BYTE_W-1:0] HI_LIM = BYTE_W'(10 << DIGIT_W);
    localparam logic [BYTE_W-1:0] HI_COR = BYTE_W'(6 << DIGIT_W);

    logic [BYTE_W-1:0] stepped;
    logic              sgn_ovf;

    always_comb begin
        c_out   = mid_cb || (mid >= HI_LIM);
        stepped = (op == BCD_ADD) ? mid + HI_COR : mid - HI_COR;
        // positive constant: add overflows pos->neg, subtract neg->pos
        if (op == BCD_ADD) begin
            sgn_ovf = !mid[MSB] && stepped[MSB];
        end else begin
            sgn_ovf = mid[MSB] && !stepped[MSB];
        end
        res   = c_out ? stepped : mid;
        v_out = c_out && sgn_ovf;
    end
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
    import bcd_alu_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_op,
    input  logic [2*DIGIT_W-1:0]   in_dst,
    input  logic [2*DIGIT_W-1:0]   in_src,
    input  logic                   in_x,
    input  logic                   in_z,
    output logic                   out_valid,
    output logic [2*DIGIT_W-1:0]   out_res,
    output logic                   out_c,
    output logic                   out_x,
    output logic                   out_v,
    output logic                   out_n,
    output logic                   out_z
);
    localparam int BYTE_W = 2 * DIGIT_W;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] res;
        bcd_flags_t        flags;
    } stage_t;

    bcd_op_e           op;
    logic [BYTE_W-1:0] lo_fixed;
    logic [BYTE_W-1:0] mid;
    logic              mid_cb;
    logic [BYTE_W-1:0] res_c;
    logic              c_c;
    logic              v_c;
    logic              accept;
    stage_t            stage_d;
    stage_t            stage_q;

    assign op       = bcd_op_e'(in_op);
    assign in_ready = !rst;
    assign accept   = in_valid && in_ready;

    bcd_low_digit #(.DIGIT_W(DIGIT_W)) i_low (
        .op       (op),
        .dst_lo   (in_dst[DIGIT_W-1:0]),
        .src_lo   (in_src[DIGIT_W-1:0]),
        .x_in     (in_x),
        .lo_fixed (lo_fixed)
    );

    bcd_high_merge #(.DIGIT_W(DIGIT_W)) i_high (
        .op       (op),
        .lo_fixed (lo_fixed),
        .dst_hi   (in_dst[BYTE_W-1:DIGIT_W]),
        .src_hi   (in_src[BYTE_W-1:DIGIT_W]),
        .mid      (mid),
        .mid_cb   (mid_cb)
    );

    bcd_decimal_adjust #(.DIGIT_W(DIGIT_W)) i_adj (
        .op     (op),
        .mid    (mid),
        .mid_cb (mid_cb),
        .res    (res_c),
        .c_out  (c_c),
        .v_out  (v_c)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = accept;
        if (accept) begin
            stage_d.res     = res_c;
            stage_d.flags.c = c_c;
            stage_d.flags.x = c_c;
            stage_d.flags.v = v_c;
            stage_d.flags.n = res_c[BYTE_W-1];
            stage_d.flags.z = (res_c == '0) ? in_z : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign out_res   = stage_q.res;
    assign out_c     = stage_q.flags.c;
    assign out_x     = stage_q.flags.x;
    assign out_v     = stage_q.flags.v;
    assign out_n     = stage_q.flags.n;
    assign out_z     = stage_q.flags.z;
endmodule

// File: rtl/bcd_byte_alu_chk.sv
module bcd_byte_alu_chk #(
    parameter int DIGIT_W = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 in_z,
    input logic                 out_valid,
    input logic [2*DIGIT_W-1:0] out_res,
    input logic                 out_c,
    input logic                 out_x,
    input logic                 out_v,
    input logic                 out_n,
    input logic                 out_z
);
    localparam int BYTE_W = 2 * DIGIT_W;
    localparam logic [BYTE_W-1:0] HI_LIM = BYTE_W'(10 << DIGIT_W);

    // R4
    no_fix_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_c) |-> (out_res < HI_LIM));

    // R5
    ovf_needs_fix_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_v) |-> out_c);

    // R6
    x_tracks_c_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_x == out_c));

    // R7
    sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_n == out_res[BYTE_W-1]));

    // R8
    nonzero_clears_z_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_res != '0)) |-> !out_z);

    // R8
    zero_keeps_z_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_res == '0)) |-> (out_z == $past(in_z)));

    // R9
    accept_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> (!out_valid && $stable(out_res) && $stable(out_c)));

    // R10
    reset_clears_valid_chk: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind bcd_byte_alu bcd_byte_alu_chk #(.DIGIT_W(DIGIT_W)) i_bcd_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_z      (in_z),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_c     (out_c),
    .out_x     (out_x),
    .out_v     (out_v),
    .out_n     (out_n),
    .out_z     (out_z)
);

// File: tb/test_bcd_byte_alu.sv
`timescale 1ns/1ps
module test_bcd_byte_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_op = 1'b0;
    logic [7:0] in_dst = '0;
    logic [7:0] in_src = '0;
    logic       in_x = 1'b0;
    logic       in_z = 1'b0;
    logic       out_valid;
    logic [7:0] out_res;
    logic       out_c, out_x, out_v, out_n, out_z;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bcd_byte_alu #(.DIGIT_W(4)) i_bcd_byte_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dst(in_dst), .in_src(in_src), .in_x(in_x), .in_z(in_z),
        .out_valid(out_valid), .out_res(out_res), .out_c(out_c), .out_x(out_x),
        .out_v(out_v), .out_n(out_n), .out_z(out_z)
    );

    // integer model: returns {res, c, v, n, z}
    function automatic logic [11:0] ref_model(input bit sub, input int d, input int s,
                                              input bit x, input bit z);
        int lo, t, full, r, sr, s2, r2;
        bit c, v;
        lo = sub ? (d % 16) - (s % 16) - x : (d % 16) + (s % 16) + x;
        lo = (lo + 256) % 256;
        if (lo >= 10) lo = sub ? lo - 6 : lo + 6;
        lo = (lo + 256) % 256;
        t = (lo + (d / 16) * 16) % 256;
        full = sub ? t - (s / 16) * 16 : t + (s / 16) * 16;
        c = sub ? (full < 0) : (full > 255);
        r = (full + 256) % 256;
        if (r >= 160) c = 1'b1;
        v = 1'b0;
        r2 = r;
        if (c) begin
            sr = (r >= 128) ? r - 256 : r;
            s2 = sub ? sr - 96 : sr + 96;
            v = (s2 > 127) || (s2 < -128);
            r2 = (s2 + 256) % 256;
        end
        return {r2[7:0], c, v, r2[7], (r2 == 0) ? z : 1'b0};
    endfunction

    task automatic check_out(input string req, input logic [7:0] er, input logic ec,
                             input logic ev, input logic ez);
        checks++;
        if (out_valid !== 1'b1 || out_res !== er || out_c !== ec || out_x !== ec ||
            out_v !== ev || out_n !== er[7] || out_z !== ez) begin
            errors++;
            $display("FAIL %s: got valid=%b res=%h c=%b x=%b v=%b n=%b z=%b, expected valid=1 res=%h c=%b x=%b v=%b n=%b z=%b",
                     req, out_valid, out_res, out_c, out_x, out_v, out_n, out_z,
                     er, ec, ec, ev, er[7], ez);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic send(input logic op, input logic [7:0] d, input logic [7:0] s,
                        input logic x, input logic z);
        @(negedge clk);
        in_op = op; in_dst = d; in_src = s; in_x = x; in_z = z; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        check_bit("R10 out_valid in reset", out_valid, 1'b0);
        check_bit("R10 in_ready in reset", in_ready, 1'b0);
        rst = 1'b0;
        #1;
        check_bit("R10 in_ready after reset", in_ready, 1'b1);
    endtask

    task automatic t_decimal;
        send(1'b0, 8'h99, 8'h01, 1'b0, 1'b1); check_out("R1 R3 R4 99+01", 8'h00, 1'b1, 1'b0, 1'b1);
        send(1'b1, 8'h00, 8'h01, 1'b0, 1'b0); check_out("R1 R4 00-01", 8'h99, 1'b1, 1'b0, 1'b0);
        send(1'b0, 8'h45, 8'h38, 1'b1, 1'b0); check_out("R1 R3 45+38+X", 8'h84, 1'b0, 1'b0, 1'b0);
        send(1'b1, 8'h52, 8'h27, 1'b0, 1'b0); check_out("R3 52-27", 8'h25, 1'b0, 1'b0, 1'b0);
        send(1'b1, 8'h52, 8'h27, 1'b1, 1'b0); check_out("R1 52-27-X", 8'h24, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_invalid_digits;
        send(1'b0, 8'h0F, 8'h0F, 1'b0, 1'b0); check_out("R2 0F+0F", 8'h24, 1'b0, 1'b0, 1'b0);
        send(1'b1, 8'h0F, 8'h00, 1'b0, 1'b0); check_out("R2 0F-00", 8'h09, 1'b0, 1'b0, 1'b0);
        send(1'b1, 8'h00, 8'h00, 1'b1, 1'b0); check_out("R2 00-00-X wrap", 8'h99, 1'b1, 1'b0, 1'b0);
        send(1'b0, 8'hFF, 8'hFF, 1'b1, 1'b0); check_out("R2 R4 FF+FF+X", 8'h65, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_overflow;
        send(1'b0, 8'h90, 8'h90, 1'b0, 1'b0); check_out("R5 add overflow", 8'h80, 1'b1, 1'b1, 1'b0);
        send(1'b1, 8'h00, 8'h40, 1'b0, 1'b0); check_out("R5 sub overflow", 8'h60, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_sticky_zero;
        send(1'b0, 8'h99, 8'h01, 1'b0, 1'b0); check_out("R8 zero result, z_in 0", 8'h00, 1'b1, 1'b0, 1'b0);
        send(1'b1, 8'h00, 8'h00, 1'b0, 1'b1); check_out("R8 zero result, z_in 1", 8'h00, 1'b0, 1'b0, 1'b1);
        send(1'b0, 8'h45, 8'h38, 1'b1, 1'b1); check_out("R8 nonzero clears z", 8'h84, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_handshake;
        send(1'b0, 8'h12, 8'h34, 1'b0, 1'b0); check_out("R9 accepted", 8'h46, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check_bit("R9 idle valid low", out_valid, 1'b0);
        checks++;
        if (out_res !== 8'h46) begin
            errors++;
            $display("FAIL R9 idle hold: got %h expected 46", out_res);
        end
        // reset arriving while a result is pending
        @(negedge clk);
        in_op = 1'b0; in_dst = 8'h01; in_src = 8'h01; in_x = 1'b0; in_z = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        check_bit("R9 valid before reset", out_valid, 1'b1);
        @(negedge clk);
        check_bit("R10 reset clears valid", out_valid, 1'b0);
        check_bit("R10 ready low in reset", in_ready, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_sweep;
        logic [11:0] exp_q = '0;
        bit have = 1'b0;
        for (int i = 0; i < 131072; i++) begin
            @(negedge clk);
            if (have) check_out("R1 R2 R3 R4 R5 R8 sweep", exp_q[11:4], exp_q[3], exp_q[2], exp_q[0]);
            in_op = i[16]; in_dst = i[15:8]; in_src = i[7:0];
            in_x = ^i[3:0] ^ i[12]; in_z = i[9] ^ i[2];
            in_valid = 1'b1;
            exp_q = ref_model(in_op, int'(in_dst), int'(in_src), in_x, in_z);
            have = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R7 sweep last", exp_q[11:4], exp_q[3], exp_q[2], exp_q[0]);
    endtask

    initial begin
        t_reset();
        t_decimal();
        t_invalid_digits();
        t_overflow();
        t_sticky_zero();
        t_handshake();
        t_sweep();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule